// File: doc/BRIEF.md
# Event-Started One-Shot Debounce Timer

This block cleans up a noisy contact input, such as a push button, without any processor involvement. The raw input is brought into the clock domain through a two-stage synchronizer, and a rising edge on the synchronized signal is treated as an event. When the block is idle and enabled, an event starts a one-shot counter. While the counter runs, the block reports itself busy and discards every further event, so contact bounce cannot restart or extend the window.

When the count reaches the programmed period, the block returns to idle and sets a sticky interrupt flag. A host that sleeps through the whole sequence is woken only by that flag, and it acknowledges the flag with a one-cycle clear pulse. Dropping the enable stops a running count at once, and no interrupt is raised for that count.

Top module: `evt_oneshot_debounce`

## Requirements
- R1: With the block idle and `enable` high, a 0-to-1 change on `raw_in` made just before clock edge k makes `busy` read 1 after edge k+2 and not after edge k+1. The internal count starts at zero on that edge.
- R2: While `busy` is 1, further rising or falling changes on `raw_in` have no effect: with period P, `busy` stays 1 for exactly P+1 clock cycles after it rises.
- R3: On the edge after the count equals the captured period, `busy` falls to 0 and `irq_flag` becomes 1 on that same edge.
- R4: An event whose synchronized edge falls in the last busy cycle (count equal to period) is ignored; `busy` stays 0 afterwards, and a later event starts the timer again.
- R5: `irq_flag` stays 1 until a one-cycle `irq_clr` pulse clears it on the next edge; when `irq_clr` is high in the cycle that the flag is being set, the flag ends up 1.
- R6: When `enable` is 0, `busy` is 0 after the next edge, no interrupt is raised for the aborted count, and events are ignored while `enable` stays 0.
- R7: `period` is captured when the timer starts; changing it while `busy` is 1 does not alter the length of the current run.
- R8: After reset, `busy` and `irq_flag` read 0.
- R9: Only a rising edge is an event: `raw_in` held at 1 or falling to 0 does not start the timer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| raw_in | input | 1 | Unsynchronized event input |
| period | input | CNT_W | Terminal count; a run lasts period+1 cycles |
| enable | input | 1 | Timer enable; low forces idle |
| irq_clr | input | 1 | One-cycle pulse that clears the interrupt flag |
| irq_flag | output | 1 | Sticky overflow interrupt flag |
| busy | output | 1 | High while the one-shot count is running |

## Verification
The embedded properties check on every cycle how an event starts the timer from zero. They also check that a running count advances by one without restarting, that the count never passes the captured period, that overflow clears busy and sets the flag, that the flag holds until it is cleared, and that a low enable forces idle. The exact three-edge start latency through the synchronizer, the run length measured at the ports, how bounce pulses and a late event at the overflow cycle are discarded, and the rule that only rising edges count can be shown only by the bench's directed scenarios, which drive `raw_in` at chosen edges.

// File: rtl/evt_oneshot_debounce.sv
module evt_oneshot_debounce #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raw_in,
  input  logic [CNT_W-1:0] period,
  input  logic             enable,
  input  logic             irq_clr,
  output logic             irq_flag,
  output logic             busy
);

  logic             sync_a, sync_b, sync_prev;
  logic             running;
  logic [CNT_W-1:0] cnt, period_q;
  logic             rise, start, ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a    <= 1'b0;
      sync_b    <= 1'b0;
      sync_prev <= 1'b0;
    end else begin
      sync_a    <= raw_in;
      sync_b    <= sync_a;
      sync_prev <= sync_b;
    end
  end

  assign rise  = sync_b & ~sync_prev;
  assign start = rise & enable & ~running;
  assign ovf   = running & enable & (cnt == period_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running  <= 1'b0;
      cnt      <= '0;
      period_q <= '0;
    end else if (!enable) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (start) begin
      running  <= 1'b1;
      cnt      <= '0;
      period_q <= period;
    end else if (ovf) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (running) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq_flag <= 1'b0;
    else if (ovf)     irq_flag <= 1'b1;
    else if (irq_clr) irq_flag <= 1'b0;
  end

  assign busy = running;

  p_start_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && enable && !busy) |=> (busy && cnt == '0));

  p_lockout_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && enable && cnt != period_q) |=> (busy && cnt == $past(cnt) + 1'b1));

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt <= period_q));

  p_ovf_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && enable && cnt == period_q) |=> (irq_flag && !busy));

  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !irq_clr) |=> irq_flag);

  p_disable_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !busy);

  p_no_irq_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !irq_flag) |=> !irq_flag);

  p_period_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(period_q));

endmodule

// File: tb/evt_oneshot_debounce_test.sv
module evt_oneshot_debounce_test;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             raw_in = 1'b0;
  logic [CNT_W-1:0] period = '0;
  logic             enable = 1'b1;
  logic             irq_clr = 1'b0;
  logic             irq_flag, busy;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  evt_oneshot_debounce #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .raw_in(raw_in), .period(period),
    .enable(enable), .irq_clr(irq_clr), .irq_flag(irq_flag), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic settle();
    raw_in = 1'b0;
    step(3);
  endtask

  task automatic clear_irq();
    irq_clr = 1'b1;
    step(1);
    irq_clr = 1'b0;
    chk("R5", "flag cleared by pulse", irq_flag, 1'b0);
  endtask

  task automatic t_reset();
    chk("R8", "busy after reset", busy, 1'b0);
    chk("R8", "irq after reset", irq_flag, 1'b0);
  endtask

  task automatic t_bounce();
    settle();
    period = 16'd10;
    raw_in = 1'b1;
    step(2);
    chk("R1", "not busy after two edges", busy, 1'b0);
    step(1);
    chk("R1", "busy after third edge", busy, 1'b1);
    raw_in = 1'b0; step(1);
    raw_in = 1'b1; step(1);
    raw_in = 1'b0; step(1);
    raw_in = 1'b1; step(1);
    step(6);
    chk("R2", "still busy at last cycle despite bounce", busy, 1'b1);
    step(1);
    chk("R3", "busy drops after period", busy, 1'b0);
    chk("R3", "irq set at overflow", irq_flag, 1'b1);
    step(1);
    chk("R5", "irq holds without clear", irq_flag, 1'b1);
    step(3);
    chk("R9", "steady high does not restart", busy, 1'b0);
    raw_in = 1'b0;
    step(4);
    chk("R9", "falling edge does not restart", busy, 1'b0);
    clear_irq();
  endtask

  task automatic t_period_zero();
    settle();
    period = 16'd0;
    raw_in = 1'b1;
    step(3);
    chk("R2", "period 0 busy one cycle", busy, 1'b1);
    step(1);
    chk("R3", "period 0 overflow", busy, 1'b0);
    chk("R3", "period 0 irq", irq_flag, 1'b1);
  endtask

  task automatic t_set_wins();
    settle();
    clear_irq();
    period = 16'd3;
    raw_in = 1'b1;
    step(3);
    step(3);
    chk("R2", "busy at count equal to period", busy, 1'b1);
    irq_clr = 1'b1;
    step(1);
    irq_clr = 1'b0;
    chk("R5", "set wins over clear", irq_flag, 1'b1);
    chk("R3", "idle after overflow", busy, 1'b0);
    clear_irq();
  endtask

  task automatic t_period_latch();
    settle();
    period = 16'd4;
    raw_in = 1'b1;
    step(3);
    period = 16'd20;
    step(4);
    chk("R7", "busy through captured period", busy, 1'b1);
    step(1);
    chk("R7", "length unchanged by new period", busy, 1'b0);
    clear_irq();
  endtask

  task automatic t_ovf_event();
    settle();
    period = 16'd6;
    raw_in = 1'b1;
    step(1);
    raw_in = 1'b0;
    step(6);
    raw_in = 1'b1;
    step(2);
    chk("R4", "busy in overflow cycle", busy, 1'b1);
    step(1);
    chk("R4", "idle after overflow", busy, 1'b0);
    chk("R4", "irq at overflow", irq_flag, 1'b1);
    step(3);
    chk("R4", "overflow-cycle event ignored", busy, 1'b0);
    raw_in = 1'b0;
    step(2);
    raw_in = 1'b1;
    step(3);
    chk("R4", "re-armed by later event", busy, 1'b1);
    step(7);
    chk("R3", "second run ends", busy, 1'b0);
    clear_irq();
  endtask

  task automatic t_disable();
    settle();
    period = 16'd8;
    raw_in = 1'b1;
    step(3);
    chk("R1", "busy before disable", busy, 1'b1);
    step(2);
    enable = 1'b0;
    step(1);
    chk("R6", "disable forces idle", busy, 1'b0);
    step(12);
    chk("R6", "no irq for aborted run", irq_flag, 1'b0);
    raw_in = 1'b0;
    step(2);
    raw_in = 1'b1;
    step(5);
    chk("R6", "event ignored while disabled", busy, 1'b0);
    chk("R6", "no irq while disabled", irq_flag, 1'b0);
    enable = 1'b1;
    step(3);
    chk("R9", "enable with input high starts nothing", busy, 1'b0);
  endtask

  initial begin
    step(2);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_bounce();
    t_period_zero();
    t_set_wins();
    t_period_latch();
    t_ovf_event();
    t_disable();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule